// File: doc/BRIEF.md
# Byte-Bus GPIO Port Bank

This block is a bank of eight bidirectional general-purpose I/O ports, each eight pins wide, on a simple byte-wide register bus. Software writes an output latch and a direction setting for each port and reads back a byte that mixes latched values and sampled pin levels. The block drives per-pin output-enable and output-value buses toward the pad ring and takes the raw pin levels in.

Every port owns two neighbouring addresses: the data latch at the even address `2*p` and the direction control at `2*p+1`. Direction controls cannot be read back. Ports 0 and 1 are switched as a whole from one control bit. The other ports are switched pin by pin, some with missing bits. Port 3 has no direction control and always stays an input. Pin levels pass through a two-flop synchronizer before the bus sees them. A read returns its data one cycle after the read strobe.

Top module: `gpio_bank`

## Requirements
- R1: After reset all output enables are 0, all output latches are 0, and `rdata_o` is 0x00.
- R2: A write to even address `2*p` loads the port-p output latch, which always drives `pin_out_o[8p+7:8p]`, whatever the pin direction. Other addresses leave the latch unchanged.
- R3: For ports 2, 5 and 6, a write to address `2*p+1` sets `pin_oe_o[8p+i]` to data bit i. A 1 makes the pin an output and a 0 makes it an input.
- R4: Port 4 direction bit 0 and port 7 direction bits 7..2 do not exist. The matching output enables stay 0 whatever value is written. Port 4 (address 0x09) keeps bits 7..1 and port 7 (address 0x0F) keeps bits 1..0.
- R5: For ports 0 and 1 (direction addresses 0x01 and 0x03), written bit 0 sets all eight output enables of the port to that value. Bits 7..1 are ignored.
- R6: Port 3 has no direction control. Its output enables are always 0, and a write to 0x07 has no effect.
- R7: A read of even address `2*p` returns, for each bit, the output latch when that pin's enable is 1, and the synchronized pin level when it is 0.
- R8: A read of any odd (direction) address returns 0x00.
- R9: `rdata_o` carries the value for a read strobe sampled at clock edge k from just after edge k until edge k+1. After an edge with no read strobe it is 0x00.
- R10: A pin level change made before edge E1 is first returned by a read sampled at edge E3. Reads sampled at E1 and E2 still return the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register byte address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, registered |
| pin_i | input | 64 | Raw pin levels, port p at bits 8p+7..8p |
| pin_oe_o | output | 64 | Per-pin output enable |
| pin_out_o | output | 64 | Per-pin output value |

## Verification
Writes show on `pin_oe_o` and `pin_out_o` right after the edge that samples the strobe. The bench checks them at the following falling edge. Read data is due at the falling edge after the sampling edge. After every pin change the bench waits three or more edges before reading, because a new level reaches the bus at the third edge. The synchronizer timing test samples the edges at the second and third edge after the change one by one.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [0:0] {DIR_PIN = 1'b0, DIR_PORT = 1'b1} dir_mode_e;

  function automatic dir_mode_e port_mode(input int p);
    return (p == 0 || p == 1) ? DIR_PORT : DIR_PIN;
  endfunction

  // implemented direction bits per port
  function automatic logic [31:0] dir_mask(input int p);
    case (p)
      0, 1:    return 32'h0000_0001;
      3:       return 32'h0000_0000;
      4:       return 32'hFFFF_FFFE;
      7:       return 32'h0000_0003;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_bank_pkg::*;
#(
  parameter int PORT_IDX = 0,
  parameter int PORT_W   = 8,
  parameter int ADDR_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic [PORT_W-1:0] pin_sync_i,
  output logic [PORT_W-1:0] oe_o,
  output logic [PORT_W-1:0] out_o,
  output logic [PORT_W-1:0] rd_val_o
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(2 * PORT_IDX);
  localparam logic [ADDR_W-1:0] DIR_ADDR  = ADDR_W'(2 * PORT_IDX + 1);
  localparam dir_mode_e         MODE      = port_mode(PORT_IDX);
  localparam logic [PORT_W-1:0] MASK      = PORT_W'(dir_mask(PORT_IDX));

  logic data_sel, dir_sel;
  logic [PORT_W-1:0] lat_q;

  assign data_sel = wr_i && (addr_i == DATA_ADDR);
  assign dir_sel  = wr_i && (addr_i == DIR_ADDR);

  // latch loads regardless of direction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lat_q <= '0;
    else if (data_sel) lat_q <= wdata_i;
  end

  generate
    if (MODE == DIR_PORT) begin : g_port_dir
      logic dir_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      dir_q <= 1'b0;
        else if (dir_sel) dir_q <= |(wdata_i & MASK);
      end
      assign oe_o = {PORT_W{dir_q}};

      p_port_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dir_sel |=> oe_o == {PORT_W{$past(wdata_i[0])}});
    end else begin : g_pin_dir
      logic [PORT_W-1:0] dir_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      dir_q <= '0;
        else if (dir_sel) dir_q <= wdata_i & MASK;
      end
      assign oe_o = dir_q;

      p_pin_dir_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dir_sel |=> oe_o == ($past(wdata_i) & MASK));
    end
  endgenerate

  assign out_o    = lat_q;
  assign rd_val_o = (oe_o & lat_q) | (~oe_o & pin_sync_i);

  p_data_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_sel |=> out_o == $past(wdata_i));
  p_data_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_sel |=> $stable(out_o));
  p_dir_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_sel |=> $stable(oe_o));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NUM_PORTS   = 8,
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [$clog2(NUM_PORTS):0]    addr_i,
  input  logic [PORT_W-1:0]             wdata_i,
  input  logic                          wr_i,
  input  logic                          rd_i,
  output logic [PORT_W-1:0]             rdata_o,
  input  logic [NUM_PORTS*PORT_W-1:0]   pin_i,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_oe_o,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_out_o
);
  localparam int ADDR_W = $clog2(NUM_PORTS) + 1;
  localparam int PINS   = NUM_PORTS * PORT_W;

  logic [PINS-1:0]   pin_sync;
  logic [PORT_W-1:0] rd_val [NUM_PORTS];
  logic [PORT_W-1:0] rdata_d;
  logic [ADDR_W-2:0] port_idx;

  gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    gpio_port #(.PORT_IDX(p), .PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_port (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .addr_i    (addr_i),
      .wdata_i   (wdata_i),
      .wr_i      (wr_i),
      .pin_sync_i(pin_sync[p*PORT_W +: PORT_W]),
      .oe_o      (pin_oe_o[p*PORT_W +: PORT_W]),
      .out_o     (pin_out_o[p*PORT_W +: PORT_W]),
      .rd_val_o  (rd_val[p])
    );
  end

  assign port_idx = addr_i[ADDR_W-1:1];

  // direction addresses are write-only
  always_comb begin
    rdata_d = '0;
    if (rd_i && !addr_i[0] && (int'(port_idx) < NUM_PORTS)) rdata_d = rd_val[port_idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rdata_d;
  end

  p_rd_dir_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[0]) |=> rdata_o == '0);
  p_rd_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> rdata_o == '0);
  p_port3_input_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> pin_oe_o[3*PORT_W +: PORT_W] == '0);
endmodule

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata;
  logic [63:0] pins = '0;
  logic [63:0] oe, outv;

  logic [7:0] m_lat [8];
  logic [7:0] m_oe  [8];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  gpio_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata),
    .pin_i(pins), .pin_oe_o(oe), .pin_out_o(outv)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_oe(input int p, input logic [7:0] d);
    case (p)
      0, 1:    return {8{d[0]}};
      3:       return 8'h00;
      4:       return d & 8'hFE;
      7:       return d & 8'h03;
      default: return d;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    int p;
    p = a[3:1];
    if (a[0]) return 8'h00;
    return (m_oe[p] & m_lat[p]) | (~m_oe[p] & pins[p*8 +: 8]);
  endfunction

  function automatic logic [63:0] m_oe_flat();
    logic [63:0] v;
    for (int p = 0; p < 8; p++) v[p*8 +: 8] = m_oe[p];
    return v;
  endfunction

  function automatic logic [63:0] m_out_flat();
    logic [63:0] v;
    for (int p = 0; p < 8; p++) v[p*8 +: 8] = m_lat[p];
    return v;
  endfunction

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (a[0]) m_oe[a[3:1]] = exp_oe(int'(a[3:1]), d);
    else      m_lat[a[3:1]] = d;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    d = rdata;
    rd = 1'b0;
  endtask

  task automatic chk_pins(input string req);
    chk({req, " oe"}, oe, m_oe_flat());
    chk({req, " out"}, outv, m_out_flat());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED_0042));
    for (int p = 0; p < 8; p++) begin m_lat[p] = '0; m_oe[p] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", oe, 64'h0);
    chk("R1 out", outv, 64'h0);
    chk("R1 rdata", {56'h0, rdata}, 64'h0);

    // R10 synchronizer latency on port 2 (input)
    @(negedge clk);
    pins[23:16] = 8'hC3; addr = 4'h4; rd = 1'b1;
    @(negedge clk); chk("R10 edge1", {56'h0, rdata}, 64'h00);
    @(negedge clk); chk("R10 edge2", {56'h0, rdata}, 64'h00);
    @(negedge clk); chk("R10 edge3", {56'h0, rdata}, 64'hC3);
    rd = 1'b0;
    // R9 idle returns zero
    @(negedge clk); chk("R9 idle", {56'h0, rdata}, 64'h00);

    // R3 per-pin direction
    bus_wr(4'h5, 8'hA5); chk_pins("R3");
    chk("R3 p2", {56'h0, oe[23:16]}, 64'hA5);
    // R8 direction read returns zero
    bus_rd(4'h5, d); chk("R8 dir p2", {56'h0, d}, 64'h00);

    // R4 missing bits
    bus_wr(4'h9, 8'hFF); chk("R4 p4", {56'h0, oe[39:32]}, 64'hFE);
    bus_wr(4'hF, 8'hFF); chk("R4 p7", {56'h0, oe[63:56]}, 64'h03);

    // R5 whole-port direction
    bus_wr(4'h1, 8'hFE); chk("R5 p0 bit0 low", {56'h0, oe[7:0]}, 64'h00);
    bus_wr(4'h1, 8'h01); chk("R5 p0 out", {56'h0, oe[7:0]}, 64'hFF);
    bus_wr(4'h3, 8'h81); chk("R5 p1 out", {56'h0, oe[15:8]}, 64'hFF);
    chk_pins("R5");

    // R6 port 3 fixed input
    bus_wr(4'h6, 8'h99);
    bus_wr(4'h7, 8'hFF); chk("R6 oe", {56'h0, oe[31:24]}, 64'h00);
    pins[31:24] = 8'h3E; repeat (3) @(negedge clk);
    bus_rd(4'h6, d); chk("R6 read", {56'h0, d}, 64'h3E);

    // R2 latch written while input, then switched to output
    bus_wr(4'hC, 8'h3C); chk("R2 out", {56'h0, outv[55:48]}, 64'h3C);
    chk("R2 still input", {56'h0, oe[55:48]}, 64'h00);
    bus_wr(4'hD, 8'hFF); chk("R2 driven", {48'h0, oe[55:48], outv[55:48]}, 64'hFF3C);

    // R7 mixed read on port 5
    bus_wr(4'hB, 8'h0F); bus_wr(4'hA, 8'hAA);
    pins[47:40] = 8'h55; repeat (3) @(negedge clk);
    bus_rd(4'hA, d); chk("R7 mixed", {56'h0, d}, 64'h5A);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [3:0] a;
      op = int'($urandom % 7);
      a  = 4'($urandom);
      if (op < 3) begin
        bus_wr(a, 8'($urandom));
        chk_pins(a[0] ? "R3 R4 R5 R6 rand" : "R2 rand");
      end else if (op < 6) begin
        bus_rd(a, d);
        chk(a[0] ? "R8 rand" : "R7 rand", {56'h0, d}, {56'h0, exp_rd(a)});
        @(negedge clk);
        chk("R9 rand", {56'h0, rdata}, 64'h0);
      end else begin
        pins = {$urandom, $urandom};
        repeat (3) @(negedge clk);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule